// File: doc/BRIEF.md
# Word-Oriented Prime-Field Keystream Generator

This block is a stream-cipher core that turns a 256-bit key and a 128-bit IV into a sequence of 32-bit keystream words. Its state is a sixteen-cell shift register of 31-bit cells, whose feedback is computed in the field of integers modulo the prime 2^31−1, and a pair of 32-bit nonlinear registers. Each step reorganizes halves of selected cells into four 32-bit words. These words are mixed with the two registers by a 32-bit addition and XOR. The result then passes through two fixed linear diffusion maps and a layer of byte substitutions.

A one-cycle `start` pulse loads the state from key, IV and built-in constants. The core then spends 32 steps mixing its own nonlinear output back into the shift register. It makes one more step whose output is thrown away, and then emits one keystream word per clock until a full frame has been produced. The message XOR and any integrity construction sit outside the block, which only supplies the words, a valid strobe and the word's position in the frame.

Top module: `kgen_top`

## Requirements
- R1: While `rstN` is low, and afterwards until the first `start`, `ksValid` is 0; reset clears `ksWord` and `ksIndex` to 0.
- R2: On a clock edge with `start` high, each cell i (0..15) is loaded with the 31-bit value {K[i], C[i], K[i+16], V[i]}. Here key byte K[j] is `key[255-8j -: 8]` and IV byte V[i] is `iv[127-8i -: 8]`. The 7-bit constant C[i] equals ((37·i + 42) mod 126) + 1. Both nonlinear registers are cleared.
- R3: The new cell is computed modulo 2^31−1 as (1+2^8)·c0 + 2^20·c4 + 2^21·c10 + 2^17·c13 + 2^15·c15, plus an optional extra term. A result congruent to 0 is stored as 2^31−1. The register then shifts so that cell i takes cell i+1, and cell 15 takes the new value.
- R4: Let H(c) = c[30:15] and L(c) = c[15:0]. Then A0 = {H(c15), L(c14)}, A1 = {L(c11), H(c9)}, A2 = {L(c7), H(c5)} and A3 = {L(c2), H(c0)}. The mixer output is W = (A0 ^ Q1) + Q2 mod 2^32. The register Q1 takes Sub(D1({U1[15:0], U2[31:16]})) and Q2 takes Sub(D2({U2[15:0], U1[31:16]})), where U1 = Q1 + A1 and U2 = Q2 ^ A2. D1 XORs its input with its left rotations by 2, 10, 18 and 24. D2 does the same with rotations by 8, 14, 22 and 30.
- R5: Sub replaces bytes [31:24] and [15:8] with T0, and bytes [23:16] and [7:0] with T1. With g the inverse in GF(2^8) modulo x^8+x^4+x^3+x+1 (g(0)=0), T0(x) = g ^ rotl1(g) ^ rotl3(g) ^ 0x3E. T1(x) = g ^ rotl1(g) ^ rotl2(g) ^ rotl3(g) ^ rotl4(g) ^ 0x55.
- R6: After loading, 32 mixing steps run, each adding W>>1 as the extra term of R3. One step with no extra term follows, and its output is discarded.
- R7: The first word appears with `ksValid` high after the 34th rising edge following the edge that sampled `start`, with `ksIndex` 0. Valid words follow on consecutive cycles with `ksIndex` rising by one each time.
- R8: Exactly FRAME_WORDS valid words are produced per `start`; then `ksValid` stays low until the next `start`.
- R9: A `start` at any time, including during mixing or emission, abandons the current run. `ksValid` is low after that edge, and the output is the fresh sequence for the new key and IV.
- R10: Each emitted word equals W ^ A3, taken from the state before the step; every emission step advances the register with no extra term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load key and IV and begin a new run |
| key | input | 256 | Secret key, byte 0 in the top bits |
| iv | input | 128 | Initial value, byte 0 in the top bits |
| ksWord | output | 32 | Keystream word |
| ksValid | output | 1 | `ksWord` holds a new word this cycle |
| ksIndex | output | $clog2(FRAME_WORDS) | Position of `ksWord` in the frame |

## Verification
The bench builds the block with its default values: a frame of 625 words and 32 mixing rounds. A full frame therefore fits in about 660 cycles, and several complete frames, including the last-word boundary and the quiet period after it, can be compared word for word against an independent model. All-zero and all-ones keys and IVs stress the prime-field wrap, because an all-ones cell is the prime's zero representative. Restarts during mixing and during emission check that a new start overrides the run in progress.

// File: rtl/kgen_pkg.sv
package kgen_pkg;

  localparam logic [30:0] PRIME = 31'h7FFF_FFFF;

  typedef struct packed {
    logic load;      // capture key/IV, clear nonlinear registers
    logic advance;   // one state step
    logic initMode;  // add W>>1 into the feedback
    logic emit;      // register the output word
  } strobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_INIT, ST_FINAL, ST_RUN} state_t;

  // 7-bit load constant for cell i (R2)
  function automatic logic [6:0] padConst(input int i);
    return 7'((((i * 37) + 42) % 126) + 1);
  endfunction

  function automatic logic [30:0] rot31(input logic [30:0] x, input int k);
    return (x << k) | (x >> (31 - k));
  endfunction

  // addition modulo 2^31-1 with end-around carry (R3)
  function automatic logic [30:0] add31(input logic [30:0] a, input logic [30:0] b);
    logic [31:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[30:0] + {30'b0, s[31]};
  endfunction

  function automatic logic [31:0] rol32(input logic [31:0] x, input int k);
    return (x << k) | (x >> (32 - k));
  endfunction

  function automatic logic [31:0] diffuse1(input logic [31:0] x);
    return x ^ rol32(x, 2) ^ rol32(x, 10) ^ rol32(x, 18) ^ rol32(x, 24);
  endfunction

  function automatic logic [31:0] diffuse2(input logic [31:0] x);
    return x ^ rol32(x, 8) ^ rol32(x, 14) ^ rol32(x, 22) ^ rol32(x, 30);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return acc;
  endfunction

  // x^254 by repeated squaring: the field inverse, 0 maps to 0
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] r;
    sq = a;
    r = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq = gfMul(sq, sq);
      r = gfMul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] subA(input logic [7:0] x);
    logic [7:0] g;
    g = gfInv(x);
    return g ^ {g[6:0], g[7]} ^ {g[4:0], g[7:5]} ^ 8'h3E;
  endfunction

  function automatic logic [7:0] subB(input logic [7:0] x);
    logic [7:0] g;
    g = gfInv(x);
    return g ^ {g[6:0], g[7]} ^ {g[5:0], g[7:6]} ^ {g[4:0], g[7:5]} ^ {g[3:0], g[7:4]} ^ 8'h55;
  endfunction

endpackage

// File: rtl/kgen_sbox32.sv
// Byte substitution layer: T0 on even lanes counted from the top, T1 on odd (R5)
module kgen_sbox32
  import kgen_pkg::*;
(
  input  logic [31:0] din,
  output logic [31:0] dout
);
  for (genvar j = 0; j < 4; j++) begin : g_lane
    if (j % 2 == 0) begin : g_boxA
      assign dout[31-8*j -: 8] = subA(din[31-8*j -: 8]);
    end else begin : g_boxB
      assign dout[31-8*j -: 8] = subB(din[31-8*j -: 8]);
    end
  end
endmodule

// File: rtl/kgen_ctrl.sv
// Sequencer: load, mixing rounds, discard step, emission of one frame
module kgen_ctrl
  import kgen_pkg::*;
#(
  parameter int FRAME_WORDS = 625,
  parameter int INIT_ROUNDS = 32,
  localparam int IDX_W = $clog2(FRAME_WORDS),
  localparam int CNT_MAX = (FRAME_WORDS > INIT_ROUNDS) ? FRAME_WORDS : INIT_ROUNDS,
  localparam int CNT_W = $clog2(CNT_MAX)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output strobe_t          strb,
  output logic [IDX_W-1:0] wordIdx
);
  state_t state;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    strb.load     = start;
    strb.advance  = !start && (state != ST_IDLE);
    strb.initMode = (state == ST_INIT);
    strb.emit     = !start && (state == ST_RUN);
  end

  assign wordIdx = IDX_W'(cnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (start) begin
      state <= ST_INIT;   // R9: a start always wins
      cnt   <= '0;
    end else begin
      case (state)
        ST_INIT: begin
          if (cnt == CNT_W'(INIT_ROUNDS - 1)) begin
            state <= ST_FINAL;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FINAL: begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: begin
          if (cnt == CNT_W'(FRAME_WORDS - 1)) begin
            state <= ST_IDLE;   // R8
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/kgen_datapath.sv
// State registers, word mixer, prime-field feedback and output register
module kgen_datapath
  import kgen_pkg::*;
#(
  parameter int FRAME_WORDS = 625,
  localparam int IDX_W = $clog2(FRAME_WORDS),
  localparam int CELLS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [255:0]     key,
  input  logic [127:0]     iv,
  input  logic [IDX_W-1:0] wordIdx,
  output logic [31:0]      ksWord,
  output logic             ksValid,
  output logic [IDX_W-1:0] ksIndex,
  output logic [30:0]      newCell
);
  logic [30:0] cells [CELLS];
  logic [30:0] loadCell [CELLS];
  logic [31:0] q1, q2;
  logic [31:0] a0, a1, a2, a3;
  logic [31:0] mixW, u1, u2;
  logic [31:0] q1Next, q2Next;
  logic [30:0] fbSum, fbTotal;

  // R2: key, constant and IV bytes packed per cell
  for (genvar i = 0; i < CELLS; i++) begin : g_load
    assign loadCell[i] = {key[255-8*i -: 8], padConst(i), key[127-8*i -: 8], iv[127-8*i -: 8]};
  end

  // R4: word reorganization from cell halves
  assign a0 = {cells[15][30:15], cells[14][15:0]};
  assign a1 = {cells[11][15:0],  cells[9][30:15]};
  assign a2 = {cells[7][15:0],   cells[5][30:15]};
  assign a3 = {cells[2][15:0],   cells[0][30:15]};

  assign mixW = (a0 ^ q1) + q2;
  assign u1   = q1 + a1;
  assign u2   = q2 ^ a2;

  kgen_sbox32 i_subHi (.din(diffuse1({u1[15:0], u2[31:16]})), .dout(q1Next));
  kgen_sbox32 i_subLo (.din(diffuse2({u2[15:0], u1[31:16]})), .dout(q2Next));

  // R3: feedback as a chain of end-around-carry adds of rotated cells
  always_comb begin
    fbSum = add31(cells[0], rot31(cells[0], 8));
    fbSum = add31(fbSum, rot31(cells[4], 20));
    fbSum = add31(fbSum, rot31(cells[10], 21));
    fbSum = add31(fbSum, rot31(cells[13], 17));
    fbSum = add31(fbSum, rot31(cells[15], 15));
    fbTotal = strb.initMode ? add31(fbSum, mixW[31:1]) : fbSum;   // R6
    newCell = (fbTotal == 31'd0) ? PRIME : fbTotal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CELLS; i++) cells[i] <= '0;
      q1 <= '0;
      q2 <= '0;
    end else if (strb.load) begin
      for (int i = 0; i < CELLS; i++) cells[i] <= loadCell[i];
      q1 <= '0;
      q2 <= '0;
    end else if (strb.advance) begin
      for (int i = 0; i < CELLS - 1; i++) cells[i] <= cells[i+1];
      cells[CELLS-1] <= newCell;
      q1 <= q1Next;
      q2 <= q2Next;
    end
  end

  // R10: output word register, R1 reset values
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ksWord  <= '0;
      ksValid <= 1'b0;
      ksIndex <= '0;
    end else if (strb.emit) begin
      ksWord  <= mixW ^ a3;
      ksValid <= 1'b1;
      ksIndex <= wordIdx;
    end else begin
      ksValid <= 1'b0;
    end
  end
endmodule

// File: rtl/kgen_top.sv
module kgen_top
  import kgen_pkg::*;
#(
  parameter int FRAME_WORDS = 625,
  parameter int INIT_ROUNDS = 32,
  localparam int IDX_W = $clog2(FRAME_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [255:0]     key,
  input  logic [127:0]     iv,
  output logic [31:0]      ksWord,
  output logic             ksValid,
  output logic [IDX_W-1:0] ksIndex
);
  strobe_t          strb;
  logic [IDX_W-1:0] wordIdx;
  logic [30:0]      newCell;

  kgen_ctrl #(.FRAME_WORDS(FRAME_WORDS), .INIT_ROUNDS(INIT_ROUNDS)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .strb(strb), .wordIdx(wordIdx)
  );

  kgen_datapath #(.FRAME_WORDS(FRAME_WORDS)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .key(key), .iv(iv), .wordIdx(wordIdx),
    .ksWord(ksWord), .ksValid(ksValid), .ksIndex(ksIndex), .newCell(newCell)
  );
endmodule

// File: rtl/kgen_checker.sv
module kgen_checker #(
  parameter int FRAME_WORDS = 625,
  parameter int INIT_ROUNDS = 32,
  localparam int IDX_W = $clog2(FRAME_WORDS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             ksValid,
  input logic [IDX_W-1:0] ksIndex,
  input logic [30:0]      newCell,
  input logic             advance
);
  logic [15:0] sinceStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceStart <= '0;
    else if (start) sinceStart <= '0;
    else if (sinceStart != 16'hFFFF) sinceStart <= sinceStart + 1'b1;
  end

  p_cell_nonzero_r3: assert property (@(posedge clk) disable iff (!rstN)
    advance |-> newCell != 31'd0);

  p_first_index_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ksValid) |-> ksIndex == '0);

  p_latency_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ksValid) |-> sinceStart == 16'(INIT_ROUNDS + 2));

  p_index_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ksValid && $past(ksValid)) |-> ksIndex == $past(ksIndex) + 1'b1);

  p_index_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    ksValid |-> ksIndex <= IDX_W'(FRAME_WORDS - 1));

  p_stop_after_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ksValid && ksIndex == IDX_W'(FRAME_WORDS - 1)) |=> !ksValid);

  p_restart_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !ksValid);
endmodule

bind kgen_top kgen_checker #(.FRAME_WORDS(FRAME_WORDS), .INIT_ROUNDS(INIT_ROUNDS)) i_kgenChk (
  .clk(clk), .rstN(rstN), .start(start), .ksValid(ksValid), .ksIndex(ksIndex),
  .newCell(newCell), .advance(strb.advance)
);

// File: tb/test_kgen_top.sv
`timescale 1ns/1ps
module test_kgen_top;
  localparam int FRAME = 625;
  localparam int LAT = 34;
  localparam longint unsigned P = 64'h7FFF_FFFF;

  logic clk = 1'b0;
  logic rstN;
  logic start;
  logic [255:0] key;
  logic [127:0] iv;
  logic [31:0] ksWord;
  logic ksValid;
  logic [9:0] ksIndex;

  int total = 0;
  int bad = 0;
  int unsigned seedDummy;

  bit [7:0] sb0 [256];
  bit [7:0] sb1 [256];
  int unsigned ms [16];
  int unsigned mr1, mr2, mx3;
  int unsigned expW [FRAME];

  always #2 clk = ~clk;

  kgen_top i_kgen_top (
    .clk(clk), .rstN(rstN), .start(start), .key(key), .iv(iv),
    .ksWord(ksWord), .ksValid(ksValid), .ksIndex(ksIndex)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // ---- independent reference model ----
  function automatic bit [7:0] bMul(bit [7:0] a, bit [7:0] b);
    bit [15:0] prod = 0;
    for (int i = 0; i < 8; i++) if (b[i]) prod ^= (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (prod[i]) prod ^= (16'h11B << (i - 8));
    return prod[7:0];
  endfunction

  function automatic bit [7:0] bRot8(bit [7:0] a, int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  task automatic buildTables();
    for (int x = 0; x < 256; x++) begin
      bit [7:0] g = 0;
      for (int y = 1; y < 256; y++) if (bMul(8'(x), 8'(y)) == 8'h01) g = 8'(y);
      sb0[x] = g ^ bRot8(g, 1) ^ bRot8(g, 3) ^ 8'h3E;
      sb1[x] = g ^ bRot8(g, 1) ^ bRot8(g, 2) ^ bRot8(g, 3) ^ bRot8(g, 4) ^ 8'h55;
    end
  endtask

  function automatic int unsigned bRol(int unsigned x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic int unsigned bSub(int unsigned x);
    return {sb0[x[31:24]], sb1[x[23:16]], sb0[x[15:8]], sb1[x[7:0]]};
  endfunction

  function automatic int unsigned mStep();
    int unsigned x0, x1, x2, w, w1, w2, t1, t2;
    x0 = (((ms[15] >> 15) & 32'hFFFF) << 16) | (ms[14] & 32'hFFFF);
    x1 = ((ms[11] & 32'hFFFF) << 16) | ((ms[9] >> 15) & 32'hFFFF);
    x2 = ((ms[7] & 32'hFFFF) << 16) | ((ms[5] >> 15) & 32'hFFFF);
    mx3 = ((ms[2] & 32'hFFFF) << 16) | ((ms[0] >> 15) & 32'hFFFF);
    w = (x0 ^ mr1) + mr2;
    w1 = mr1 + x1;
    w2 = mr2 ^ x2;
    t1 = (w1 << 16) | (w2 >> 16);
    t2 = (w2 << 16) | (w1 >> 16);
    mr1 = bSub(t1 ^ bRol(t1, 2) ^ bRol(t1, 10) ^ bRol(t1, 18) ^ bRol(t1, 24));
    mr2 = bSub(t2 ^ bRol(t2, 8) ^ bRol(t2, 14) ^ bRol(t2, 22) ^ bRol(t2, 30));
    return w;
  endfunction

  task automatic mShift(input int unsigned extra);
    longint unsigned acc;
    int unsigned v;
    acc = longint'(ms[0]) * 257 + (longint'(ms[4]) << 20) + (longint'(ms[10]) << 21)
        + (longint'(ms[13]) << 17) + (longint'(ms[15]) << 15) + longint'(extra);
    v = int'(acc % P);
    if (v == 0) v = int'(P);
    for (int i = 0; i < 15; i++) ms[i] = ms[i+1];
    ms[15] = v;
  endtask

  task automatic model(input logic [255:0] k, input logic [127:0] v);
    int unsigned w;
    for (int i = 0; i < 16; i++) begin
      bit [6:0] c = 7'(((i * 37 + 42) % 126) + 1);
      ms[i] = {1'b0, k[255-8*i -: 8], c, k[127-8*i -: 8], v[127-8*i -: 8]};
    end
    mr1 = 0;
    mr2 = 0;
    for (int r = 0; r < 32; r++) begin
      w = mStep();
      mShift(w >> 1);
    end
    w = mStep();
    mShift(0);
    for (int n = 0; n < FRAME; n++) begin
      w = mStep();
      expW[n] = w ^ mx3;
      mShift(0);
    end
  endtask

  // ---- stimulus helpers (entered and left at a falling edge) ----
  task automatic pulseStart(input logic [255:0] k, input logic [127:0] v);
    start = 1'b1;
    key = k;
    iv = v;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runCase(input logic [255:0] k, input logic [127:0] v, input bit restart,
                         input string name);
    int lat = 0;
    int words = 0;
    model(k, v);
    pulseStart(k, v);
    if (restart) check(ksValid == 1'b0, "R9", {name, " valid low after restart"}, ksValid, 0);
    while (!ksValid && lat < LAT + 20) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    check(lat == LAT, "R7", {name, " start to first word"}, lat, LAT);
    // word match covers R2 R3 R4 R5 R6 R10 together
    for (int n = 0; n < FRAME; n++) begin
      if (ksValid) words++;
      check(ksValid && ksWord == expW[n], "R10", $sformatf("%s word %0d", name, n), ksWord, expW[n]);
      check(ksIndex == 10'(n), "R7", $sformatf("%s index %0d", name, n), ksIndex, n);
      @(posedge clk);
      @(negedge clk);
    end
    check(words == FRAME, "R8", {name, " words in frame"}, words, FRAME);
    for (int q = 0; q < 6; q++) begin
      check(ksValid == 1'b0, "R8", {name, " quiet after frame"}, ksValid, 0);
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic logic [255:0] rndKey();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [127:0] rndIv();
    logic [127:0] r;
    for (int i = 0; i < 4; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    seedDummy = $urandom(32'd7301);
    buildTables();
    rstN = 1'b0;
    start = 1'b0;
    key = '0;
    iv = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ksValid == 1'b0, "R1", "valid in reset", ksValid, 0);
    check(ksWord == 32'd0, "R1", "word in reset", ksWord, 0);
    check(ksIndex == 10'd0, "R1", "index in reset", ksIndex, 0);
    rstN = 1'b1;
    repeat (5) begin
      @(posedge clk);
      @(negedge clk);
      check(ksValid == 1'b0, "R1", "valid without start", ksValid, 0);
    end

    // directed corners: all-zero and all-ones material (prime wrap, R3)
    runCase('0, '0, 1'b0, "zero");
    runCase({256{1'b1}}, {128{1'b1}}, 1'b0, "ones");

    // random material
    for (int c = 0; c < 3; c++) runCase(rndKey(), rndIv(), 1'b0, $sformatf("rand%0d", c));

    // R9: restart in the middle of emission
    pulseStart(rndKey(), rndIv());
    repeat (LAT + 10) begin
      @(posedge clk);
      @(negedge clk);
    end
    check(ksValid == 1'b1, "R9", "emitting before restart", ksValid, 1);
    runCase(rndKey(), rndIv(), 1'b1, "restartRun");

    // R9: restart during the mixing rounds
    pulseStart(rndKey(), rndIv());
    repeat (10) begin
      @(posedge clk);
      @(negedge clk);
    end
    runCase(rndKey(), rndIv(), 1'b1, "restartInit");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule